// File: doc/BRIEF.md
# Audio Serial Clock Divider Chain

This block derives two audio clocks from one source clock: a master clock for converters and a serial bit clock for the data link. Both come from a cascade of divider stages. A prescaler divides by 1 or 8. A modulus counter divides by 1 to 256. A fixed halving stage turns each modulus terminal count into a 50% duty master clock. A fine counter divides the master-clock toggle rate by 1 to 16 to produce the bit clock. The source clock ticks every stage, so the whole chain is one synchronous design. Each divided output has a one-source-cycle strobe that marks its rising edge, so logic in the source domain can act on clock edges without a second clock domain.

Software chooses the divider values, and the block only applies them. The modulus and fine fields are written as the divide value minus one. A field change is picked up by each stage only when that stage next reloads, so no output period is ever cut short. A bypass control routes the source clock straight to both outputs. Separate bits invert the master clock and the bit clock. A direction bit decides whether the block drives the master clock pin or leaves it to an external source.

The control state machine has two states. ST_RUN is the divided mode, and reset enters it. ST_PASS is the bypass mode. ST_RUN moves to ST_PASS on a clock edge where the bypass input is high, and that edge also clears every counter and output register. ST_PASS returns to ST_RUN on the first edge where the bypass input is low. Division then restarts from cleared counters.

Top module: `audio_clk_divider`

## Requirements
- R1: While rst_n is low, mclk_out, mclk_stb, bclk_out and bclk_stb are all 0.
- R2: cfg_pre8 = 1 makes the prescaler divide by 8, and cfg_pre8 = 0 makes it divide by 1.
- R3: cfg_mod holds the modulus divide value minus one, so the field values 0 to 255 select division by 1 to 256.
- R4: When not in bypass, mclk_out has a period of 2·P·M source cycles with equal high and low times. P is the prescaler ratio and M = cfg_mod + 1.
- R5: cfg_fine holds the fine divide value minus one, so F = 1 to 16. bclk_out has a period of 2·P·M·F source cycles with equal high and low times. The bit clock only toggles in a cycle where the master clock toggles.
- R6: mclk_stb and bclk_stb are high for exactly the first source cycle in which the matching output is high, and for no other cycle.
- R7: A new value on cfg_pre8, cfg_mod or cfg_fine reaches a stage only when that stage's count reaches zero, so a count already in progress runs to its end.
- R8: On a clock edge where cfg_bypass is 1, the block enters bypass from the next cycle. In bypass, bclk_out follows the source clock and bclk_stb is 1. On the first edge where cfg_bypass is 0, divided mode restarts from cleared counters.
- R9: cfg_mclk_inv inverts mclk_out and cfg_bclk_inv inverts bclk_out. The strobes follow the rising edges of the inverted outputs.
- R10: mclk_oe equals cfg_mclk_drive. While it is 0, mclk_out and mclk_stb stay 0 and the bit clock keeps running unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pre8 | input | 1 | Prescaler select: 1 divides by 8, 0 divides by 1 |
| cfg_mod | input | MOD_W | Modulus divide value minus one |
| cfg_fine | input | FINE_W | Fine divide value minus one (bit clock only) |
| cfg_bypass | input | 1 | Route the source clock straight to the outputs |
| cfg_mclk_inv | input | 1 | Invert the master clock |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_mclk_drive | input | 1 | 1: the block drives the master clock pin |
| mclk_out | output | 1 | Master clock |
| mclk_oe | output | 1 | Output enable for the master clock pin |
| mclk_stb | output | 1 | One-cycle strobe on a master clock rising edge |
| bclk_out | output | 1 | Serial bit clock |
| bclk_stb | output | 1 | One-cycle strobe on a bit clock rising edge |

## Verification
Two events can fall in the same source cycle: a divider field change and a stage terminal count. The bench provokes this by rewriting cfg_mod and cfg_pre8 at arbitrary cycles while the master clock is running, so some writes land exactly on a reload cycle and others land mid-count. Every output is judged each cycle against a behavioural model that picks up new fields only at its own reloads. A second collision is between an inversion change and a toggle of the same output. It is judged by requiring that the strobe still marks one first-high cycle and never two in a row.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_PASS = 1'b1
    } div_state_t;

endpackage

// File: rtl/clkdiv_stage.sv
// Down-counting divider stage: ticks when enabled at zero, then reloads.
module clkdiv_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] reload,
    output logic         tick
);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    // R7
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/clkdiv_phase.sv
// Output phase: level toggle, polarity, gating and rising-edge strobe.
module clkdiv_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic toggle,
    input  logic inv,
    input  logic gate,
    output logic out_q,
    output logic stb_q
);

    logic lvl;
    logic lvl_n;
    logic out_n;

    assign lvl_n = lvl ^ toggle;
    assign out_n = gate & (lvl_n ^ inv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl   <= 1'b0;
            out_q <= 1'b0;
            stb_q <= 1'b0;
        end else if (clr) begin
            lvl   <= 1'b0;
            out_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            lvl   <= lvl_n;
            out_q <= out_n;
            stb_q <= out_n & ~out_q;
        end
    end

    // R6
    one_cycle_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);

    // R10
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !out_q);

endmodule

// File: rtl/audio_clk_divider.sv
module audio_clk_divider
    import clkdiv_pkg::*;
#(
    parameter int PRE_W  = 3,
    parameter int MOD_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pre8,
    input  logic [MOD_W-1:0]  cfg_mod,
    input  logic [FINE_W-1:0] cfg_fine,
    input  logic              cfg_bypass,
    input  logic              cfg_mclk_inv,
    input  logic              cfg_bclk_inv,
    input  logic              cfg_mclk_drive,
    output logic              mclk_out,
    output logic              mclk_oe,
    output logic              mclk_stb,
    output logic              bclk_out,
    output logic              bclk_stb
);

    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'((1 << PRE_W) - 1);

    div_state_t state_q;
    logic tick_pre, tick_mod, tick_fine;
    logic mq, ms, bq, bs;

    clkdiv_stage #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(cfg_bypass), .en(1'b1),
        .reload(cfg_pre8 ? PRE_MAX : '0), .tick(tick_pre)
    );

    clkdiv_stage #(.W(MOD_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .clr(cfg_bypass), .en(tick_pre),
        .reload(cfg_mod), .tick(tick_mod)
    );

    clkdiv_stage #(.W(FINE_W)) u_fine (
        .clk(clk), .rst_n(rst_n), .clr(cfg_bypass), .en(tick_mod),
        .reload(cfg_fine), .tick(tick_fine)
    );

    clkdiv_phase u_mph (
        .clk(clk), .rst_n(rst_n), .clr(cfg_bypass), .toggle(tick_mod),
        .inv(cfg_mclk_inv), .gate(cfg_mclk_drive), .out_q(mq), .stb_q(ms)
    );

    clkdiv_phase u_bph (
        .clk(clk), .rst_n(rst_n), .clr(cfg_bypass), .toggle(tick_fine),
        .inv(cfg_bclk_inv), .gate(1'b1), .out_q(bq), .stb_q(bs)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:  state_q <= cfg_bypass ? ST_PASS : ST_RUN;
                ST_PASS: state_q <= cfg_bypass ? ST_PASS : ST_RUN;
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Output selection
    always_comb begin
        mclk_oe = cfg_mclk_drive;
        unique case (state_q)
            ST_PASS: begin
                mclk_out = cfg_mclk_drive & (clk ^ cfg_mclk_inv);
                mclk_stb = cfg_mclk_drive;
                bclk_out = clk ^ cfg_bclk_inv;
                bclk_stb = 1'b1;
            end
            default: begin
                mclk_out = mq;
                mclk_stb = ms;
                bclk_out = bq;
                bclk_stb = bs;
            end
        endcase
    end

    // R5
    fine_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_fine |-> tick_mod);

    // R8
    pass_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |=> bclk_stb);

endmodule

// File: tb/tb_audio_clk_divider.sv
`timescale 1ns/1ps
module tb_audio_clk_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pre8 = 1'b0;
    logic [7:0] cfg_mod = 8'd0;
    logic [3:0] cfg_fine = 4'd0;
    logic       cfg_bypass = 1'b0;
    logic       cfg_mclk_inv = 1'b0;
    logic       cfg_bclk_inv = 1'b0;
    logic       cfg_mclk_drive = 1'b1;
    logic       mclk_out, mclk_oe, mclk_stb, bclk_out, bclk_stb;

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    audio_clk_divider dut (
        .clk(clk), .rst_n(rst_n), .cfg_pre8(cfg_pre8), .cfg_mod(cfg_mod),
        .cfg_fine(cfg_fine), .cfg_bypass(cfg_bypass), .cfg_mclk_inv(cfg_mclk_inv),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_mclk_drive(cfg_mclk_drive),
        .mclk_out(mclk_out), .mclk_oe(mclk_oe), .mclk_stb(mclk_stb),
        .bclk_out(bclk_out), .bclk_stb(bclk_stb)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: nested counts, fields taken at each reload.
    int pc, mc, fc;
    bit ml, bl, mqx, msx, bqx, bsx, pass;

    always @(posedge clk) cyc++;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc = 0; mc = 0; fc = 0; ml = 0; bl = 0;
            mqx = 0; msx = 0; bqx = 0; bsx = 0; pass = 0;
        end else if (cfg_bypass) begin
            pc = 0; mc = 0; fc = 0; ml = 0; bl = 0;
            mqx = 0; msx = 0; bqx = 0; bsx = 0; pass = 1;
        end else begin
            bit ta, tb, tc, nm, nb;
            pass = 0;
            ta = (pc == 0);
            tb = ta && (mc == 0);
            tc = tb && (fc == 0);
            pc = ta ? (cfg_pre8 ? 7 : 0) : pc - 1;
            if (ta) mc = (mc == 0) ? int'(cfg_mod) : mc - 1;
            if (tb) fc = (fc == 0) ? int'(cfg_fine) : fc - 1;
            ml = ml ^ tb;
            bl = bl ^ tc;
            nm = cfg_mclk_drive & (ml ^ cfg_mclk_inv);
            msx = nm & !mqx;
            mqx = nm;
            nb = bl ^ cfg_bclk_inv;
            bsx = nb & !bqx;
            bqx = nb;
        end
    end

    task automatic compare_all();
        bit em, ems, eb, ebs;
        em  = pass ? (cfg_mclk_drive & (clk ^ cfg_mclk_inv)) : mqx;
        ems = pass ? cfg_mclk_drive : msx;
        eb  = pass ? (clk ^ cfg_bclk_inv) : bqx;
        ebs = pass ? 1'b1 : bsx;
        chk({cur_req, " mclk_out"}, mclk_out === em, int'(mclk_out), int'(em));
        chk({cur_req, " mclk_stb"}, mclk_stb === ems, int'(mclk_stb), int'(ems));
        chk({cur_req, " bclk_out"}, bclk_out === eb, int'(bclk_out), int'(eb));
        chk({cur_req, " bclk_stb"}, bclk_stb === ebs, int'(bclk_stb), int'(ebs));
        chk({cur_req, " mclk_oe"}, mclk_oe === cfg_mclk_drive, int'(mclk_oe), int'(cfg_mclk_drive));
    endtask

    always @(posedge clk) begin
        #2 compare_all();
        #4 compare_all();
    end

    // Period between the 3rd and 4th strobes; strobe cycles must show the clock high (R6).
    task automatic measure(input string tag, input bit on_m, input int exp_p);
        int seen = 0;
        int last = 0;
        int got = 0;
        int guard = 0;
        while (seen < 4 && guard < 6000) begin
            @(posedge clk); #2;
            guard++;
            if (on_m ? mclk_stb : bclk_stb) begin
                chk("R6 output high at strobe", (on_m ? mclk_out : bclk_out) === 1'b1,
                    int'(on_m ? mclk_out : bclk_out), 1);
                if (seen > 0) got = cyc - last;
                last = cyc;
                seen++;
            end
        end
        chk(tag, got == exp_p, got, exp_p);
    endtask

    task automatic setcfg(input bit p8, input int m, input int f);
        @(negedge clk);
        cfg_pre8 = p8;
        cfg_mod = 8'(m);
        cfg_fine = 4'(f);
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        run(4);
        @(negedge clk); rst_n = 1'b1;

        cur_req = "R4";
        setcfg(0, 2, 1);
        measure("R4 mclk period P=1 M=3", 1, 6);
        cur_req = "R5";
        measure("R5 bclk period F=2", 0, 12);

        cur_req = "R2";
        setcfg(1, 1, 2);
        measure("R2 mclk period P=8 M=2", 1, 32);
        measure("R2 bclk period F=3", 0, 96);

        cur_req = "R3";
        setcfg(0, 255, 0);
        measure("R3 mclk period M=256", 1, 512);
        setcfg(0, 0, 0);
        measure("R3 mclk period M=1", 1, 2);

        cur_req = "R5";
        setcfg(0, 0, 15);
        measure("R5 bclk period F=16", 0, 32);

        cur_req = "R7";
        setcfg(0, 4, 1);
        run(7);
        setcfg(0, 2, 1);
        run(3);
        setcfg(1, 6, 2);
        run(37);
        setcfg(0, 3, 0);
        measure("R7 mclk period after change", 1, 8);

        cur_req = "R9";
        @(negedge clk); cfg_mclk_inv = 1'b1;
        run(5);
        @(negedge clk); cfg_bclk_inv = 1'b1;
        measure("R9 mclk period inverted", 1, 8);
        measure("R9 bclk period inverted", 0, 8);
        @(negedge clk); cfg_mclk_inv = 1'b0; cfg_bclk_inv = 1'b0;

        cur_req = "R8";
        @(negedge clk); cfg_bypass = 1'b1;
        @(posedge clk); #2;
        chk("R8 bclk_stb in bypass", bclk_stb === 1'b1, int'(bclk_stb), 1);
        chk("R8 bclk_out high phase", bclk_out === 1'b1, int'(bclk_out), 1);
        #4;
        chk("R8 bclk_out low phase", bclk_out === 1'b0, int'(bclk_out), 0);
        run(6);
        @(negedge clk); cfg_bclk_inv = 1'b1;
        run(4);
        @(negedge clk); cfg_bypass = 1'b0; cfg_bclk_inv = 1'b0;
        measure("R8 mclk period after bypass", 1, 8);

        cur_req = "R10";
        @(negedge clk); cfg_mclk_drive = 1'b0;
        run(2);
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #2;
            chk("R10 mclk_out gated", mclk_out === 1'b0, int'(mclk_out), 0);
            chk("R10 mclk_oe low", mclk_oe === 1'b0, int'(mclk_oe), 0);
        end
        measure("R10 bclk period while undriven", 0, 8);
        @(negedge clk); cfg_mclk_drive = 1'b1;
        run(20);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule